// File: doc/BRIEF.md
# Supply Rail Fault Supervisor

This block sits between the analog comparators of a multi-rail panel power controller and the switching stages they protect. Every input is a one-bit, already-qualified comparator result; the block turns them into per-rail disables, a sticky global shutdown, a restart request for the core buck and a switching-frequency divide code for the I/O buck. All timing is counted in ticks of a 1 µs strobe, so the qualification windows are parameters that give the full-length limits by default and can be shortened for test.

Some faults act at once and are not remembered. Over-temperature, a core output below 20% and an isolation switch over-difference belong here. Others must persist for a qualification window before they trip the sticky shutdown. The main analog rail, both gate rails and the I/O rail use a long window, and the isolation over-difference uses a short one. Input undervoltage is latched on its own and is released only when the input falls to the deep reset level. The core buck's low-side over-current is counted per switching cycle. A run of consecutive over-current cycles stops the core rail for one long window and then raises a single-cycle restart request.

Top module: `rail_fault_supervisor`

## Requirements
- R1: `main_uv` held for QUAL_TICKS consecutive ticks sets `shutdown` one clock after the last counted tick; a drop before that resets the count and `shutdown` stays 0.
- R2: With `iso_lim_code` nonzero, `iso_over` raises `boost_off` in the same cycle; held for SHORT_TICKS ticks it sets `shutdown` one clock later.
- R3: With `iso_lim_code` equal to 0, `iso_over` has no effect: `boost_off` and `shutdown` stay 0.
- R4: `ngate_high` or `pgate_low` held for QUAL_TICKS ticks each set `shutdown` one clock after the last counted tick.
- R5: `io_fdiv` is 2'b00 (full rate) normally, 2'b01 (half) while `io_uv80` is 1 and `io_uv20` is 0, 2'b10 (quarter) while `io_uv20` is 1; `io_uv80` held QUAL_TICKS ticks sets `shutdown`.
- R6: `core_uv20` raises `core_off` in the same cycle. OC_RUN consecutive `cyc_strobe` cycles with `core_oc` set raise `core_off` for QUAL_TICKS ticks, after which `core_restart` is 1 for exactly one clock. A strobe with `core_oc` low restarts the run.
- R7: `vin_uv` forces all four rail disables at once and latches them; they stay set after `vin_uv` drops, until `vin_deep` is seen at a clock edge.
- R8: `ot_flag` forces all four rail disables while it is 1 and leaves no latched state once it clears.
- R9: `shutdown` is sticky: it remains 1 after the tripping flag clears and is cleared at the next clock edge by `vin_deep` or by `chip_en` low. While it is 1, all rail disables are 1.
- R10: After reset all disables, `shutdown` and `core_restart` are 0 and `io_fdiv` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip enable; low clears the global shutdown |
| tick_us | input | 1 | 1 µs time-base strobe |
| cyc_strobe | input | 1 | One pulse per core buck switching cycle |
| main_uv | input | 1 | Main analog rail below 80% of target |
| iso_over | input | 1 | Isolation switch difference above programmed limit |
| iso_lim_code | input | LIM_W | Isolation limit code; 0 disables the check |
| ngate_high | input | 1 | Negative gate rail too far above target |
| pgate_low | input | 1 | Positive gate rail below 75% of target |
| io_uv80 | input | 1 | I/O rail below 80% of target |
| io_uv20 | input | 1 | I/O rail below 20% of target |
| core_uv20 | input | 1 | Core rail below 20% of target |
| core_oc | input | 1 | Core low-side over-current in this cycle |
| vin_uv | input | 1 | Input supply undervoltage |
| vin_deep | input | 1 | Input supply below deep reset level |
| ot_flag | input | 1 | Over-temperature |
| boost_off | output | 1 | Disable boost and isolation switch |
| io_off | output | 1 | Disable I/O buck |
| core_off | output | 1 | Disable core buck |
| gate_off | output | 1 | Disable both gate charge pumps |
| shutdown | output | 1 | Sticky global shutdown |
| core_restart | output | 1 | One-cycle core restart request |
| io_fdiv | output | 2 | I/O buck frequency divide code |

## Verification
The hardest state to reach is the hiccup restart, because it needs an unbroken run of exactly OC_RUN over-current strobes and then a full long window with nothing else disturbing the core rail. The stimulus first sends a run one strobe short, breaks it with a clean strobe and repeats the short run, so a miscounted or unreset run shows up. It then completes the run and samples `core_off` and `core_restart` on the cycles either side of the window's last tick. The qualification windows are probed in the same way, one tick short and one tick past.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  localparam int NUM_QUAL = 5;
  localparam int Q_MAIN   = 0;
  localparam int Q_NGATE  = 1;
  localparam int Q_PGATE  = 2;
  localparam int Q_IO     = 3;
  localparam int Q_ISO    = 4;

  typedef enum logic [1:0] {
    FDIV_FULL    = 2'b00,
    FDIV_HALF    = 2'b01,
    FDIV_QUARTER = 2'b10
  } fdiv_e;
endpackage

// File: rtl/fault_qual_timer.sv
module fault_qual_timer #(
  parameter int LIMIT = 50000,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flag,
  output logic expired
);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!flag)
      cnt_d = '0;
    else if (tick && (cnt_q != LIM_V))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = flag && (cnt_q == LIM_V);

  AST_EXPIRE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    expired |-> $past(flag)); // R1
endmodule

// File: rtl/oc_restart_ctrl.sv
module oc_restart_ctrl #(
  parameter int OC_RUN    = 7,
  parameter int HIC_TICKS = 50000,
  parameter int RW        = $clog2(OC_RUN + 1),
  parameter int HW        = $clog2(HIC_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic strobe,
  input  logic oc,
  output logic hiccup,
  output logic restart
);
  localparam logic [RW-1:0] RUN_LAST = RW'(OC_RUN - 1);
  localparam logic [HW-1:0] HIC_LAST = HW'(HIC_TICKS - 1);

  logic [RW-1:0] run_q, run_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          hic_q, hic_d;
  logic          pls_q, pls_d;

  always_comb begin
    run_d  = run_q;
    hcnt_d = hcnt_q;
    hic_d  = hic_q;
    pls_d  = 1'b0;
    if (hic_q) begin
      if (tick) begin
        if (hcnt_q == HIC_LAST) begin
          hic_d  = 1'b0;
          hcnt_d = '0;
          pls_d  = 1'b1;
        end else begin
          hcnt_d = hcnt_q + 1'b1;
        end
      end
    end else if (strobe) begin
      if (oc) begin
        if (run_q == RUN_LAST) begin
          hic_d  = 1'b1;
          hcnt_d = '0;
          run_d  = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
      end else begin
        run_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      hcnt_q <= '0;
      hic_q  <= 1'b0;
      pls_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      hcnt_q <= hcnt_d;
      hic_q  <= hic_d;
      pls_q  <= pls_d;
    end
  end

  assign hiccup  = hic_q;
  assign restart = pls_q;

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !restart); // R6
  AST_HICCUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hic_q) |-> $past(strobe && oc)); // R6
endmodule

// File: rtl/rail_fault_supervisor.sv
module rail_fault_supervisor #(
  parameter int QUAL_TICKS  = 50000,
  parameter int SHORT_TICKS = 200,
  parameter int OC_RUN      = 7,
  parameter int LIM_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chip_en,
  input  logic             tick_us,
  input  logic             cyc_strobe,
  input  logic             main_uv,
  input  logic             iso_over,
  input  logic [LIM_W-1:0] iso_lim_code,
  input  logic             ngate_high,
  input  logic             pgate_low,
  input  logic             io_uv80,
  input  logic             io_uv20,
  input  logic             core_uv20,
  input  logic             core_oc,
  input  logic             vin_uv,
  input  logic             vin_deep,
  input  logic             ot_flag,
  output logic             boost_off,
  output logic             io_off,
  output logic             core_off,
  output logic             gate_off,
  output logic             shutdown,
  output logic             core_restart,
  output logic [1:0]       io_fdiv
);
  import rfs_pkg::*;

  localparam int TW = $clog2(QUAL_TICKS + 1);

  logic                iso_armed;
  logic                iso_cut;
  logic [NUM_QUAL-1:0] qual_flag;
  logic [NUM_QUAL-1:0] qual_exp;
  logic                hiccup;
  logic                uvl_q, uvl_d;
  logic                shut_q, shut_d;
  logic                off_all;
  fdiv_e               fdiv;

  assign iso_armed = (iso_lim_code != '0);
  assign iso_cut   = iso_armed && iso_over;

  assign qual_flag[Q_MAIN]  = main_uv;
  assign qual_flag[Q_NGATE] = ngate_high;
  assign qual_flag[Q_PGATE] = pgate_low;
  assign qual_flag[Q_IO]    = io_uv80;
  assign qual_flag[Q_ISO]   = iso_cut;

  generate
    for (genvar gi = 0; gi < NUM_QUAL; gi++) begin : g_qual
      localparam int LIM = (gi == Q_ISO) ? SHORT_TICKS : QUAL_TICKS;
      fault_qual_timer #(.LIMIT(LIM), .W(TW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .flag    (qual_flag[gi]),
        .expired (qual_exp[gi])
      );
    end
  endgenerate

  oc_restart_ctrl #(.OC_RUN(OC_RUN), .HIC_TICKS(QUAL_TICKS)) u_oc (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_us),
    .strobe  (cyc_strobe),
    .oc      (core_oc),
    .hiccup  (hiccup),
    .restart (core_restart)
  );

  always_comb begin
    uvl_d = uvl_q;
    if (vin_deep)    uvl_d = 1'b0;
    else if (vin_uv) uvl_d = 1'b1;

    shut_d = shut_q;
    if (vin_deep || !chip_en) shut_d = 1'b0;
    else if (|qual_exp)       shut_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uvl_q  <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      uvl_q  <= uvl_d;
      shut_q <= shut_d;
    end
  end

  always_comb begin
    if (io_uv20)      fdiv = FDIV_QUARTER;
    else if (io_uv80) fdiv = FDIV_HALF;
    else              fdiv = FDIV_FULL;
  end

  assign off_all   = shut_q || uvl_q || vin_uv || ot_flag;
  assign boost_off = off_all || iso_cut;
  assign io_off    = off_all;
  assign core_off  = off_all || core_uv20 || hiccup;
  assign gate_off  = off_all;
  assign shutdown  = shut_q;
  assign io_fdiv   = fdiv;

  AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && chip_en && !vin_deep) |=> shutdown); // R9
  AST_SHUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vin_deep || !chip_en) |=> !shutdown); // R9
  AST_UV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (uvl_q && !vin_deep) |=> io_off); // R7
  AST_ISO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((iso_lim_code == '0) && !off_all) |-> !boost_off); // R3
  AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> (boost_off && io_off && core_off && gate_off)); // R8
  AST_FDIV_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    io_fdiv != 2'b11); // R5
endmodule

// File: tb/rail_fault_supervisor_bench.sv
module rail_fault_supervisor_bench;
  localparam int Q = 20;
  localparam int S = 6;
  localparam int RUN = 7;

  logic clk, rst_n, chip_en, tick_us, cyc_strobe;
  logic main_uv, iso_over, ngate_high, pgate_low, io_uv80, io_uv20;
  logic core_uv20, core_oc, vin_uv, vin_deep, ot_flag;
  logic [3:0] iso_lim_code;
  logic boost_off, io_off, core_off, gate_off, shutdown, core_restart;
  logic [1:0] io_fdiv;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  rail_fault_supervisor #(.QUAL_TICKS(Q), .SHORT_TICKS(S), .OC_RUN(RUN), .LIM_W(4)) u_rail_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .tick_us(tick_us),
    .cyc_strobe(cyc_strobe), .main_uv(main_uv), .iso_over(iso_over),
    .iso_lim_code(iso_lim_code), .ngate_high(ngate_high), .pgate_low(pgate_low),
    .io_uv80(io_uv80), .io_uv20(io_uv20), .core_uv20(core_uv20), .core_oc(core_oc),
    .vin_uv(vin_uv), .vin_deep(vin_deep), .ot_flag(ot_flag),
    .boost_off(boost_off), .io_off(io_off), .core_off(core_off), .gate_off(gate_off),
    .shutdown(shutdown), .core_restart(core_restart), .io_fdiv(io_fdiv)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  // inputs {iso,code_nz,io80,io20,core20,ot} _ expected {boost,io,core,gate,fdiv}
  localparam logic [11:0] VEC [8] = '{
    12'b000000_000000,  // R10 idle
    12'b110000_100000,  // R2 immediate cut
    12'b100000_000000,  // R3 masked by code 0
    12'b001000_000001,  // R5 half rate
    12'b001100_000010,  // R5 quarter rate
    12'b000010_001000,  // R6 core below 20%
    12'b000001_111100,  // R8 over-temperature
    12'b001101_111110   // R8 with R5 quarter
  };

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sample_offs(string tag, logic [3:0] exp);
    #1 chk(tag, {4'b0, boost_off, io_off, core_off, gate_off}, {4'b0, exp});
  endtask

  task automatic clear_shut();
    chip_en = 0;
    edges(1);
    chip_en = 1;
  endtask

  task automatic strobe(logic oc);
    cyc_strobe = 1; core_oc = oc;
    edges(1);
    cyc_strobe = 0; core_oc = 0;
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; chip_en = 1; tick_us = 1; cyc_strobe = 0;
    main_uv = 0; iso_over = 0; ngate_high = 0; pgate_low = 0;
    io_uv80 = 0; io_uv20 = 0; core_uv20 = 0; core_oc = 0;
    vin_uv = 0; vin_deep = 0; ot_flag = 0; iso_lim_code = 0;
    edges(3);
    rst_n = 1;
    edges(1);
    // R10 reset state
    #1 chk("R10 reset", {2'b0, boost_off, io_off, core_off, gate_off, shutdown, core_restart}, 8'h00);
    chk("R10 fdiv", {6'b0, io_fdiv}, 8'h00);

    // table walk
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {iso_over, iso_lim_code[0], io_uv80, io_uv20, core_uv20, ot_flag} = VEC[k][11:6];
      iso_lim_code[1] = VEC[k][10];
      #1 chk($sformatf("R5/R8 table row %0d", k),
             {2'b0, boost_off, io_off, core_off, gate_off, io_fdiv}, {2'b0, VEC[k][5:0]});
      @(negedge clk);
      {iso_over, io_uv80, io_uv20, core_uv20, ot_flag} = '0;
      iso_lim_code = 0;
    end
    edges(2);
    chk("R2 no trip from table", {7'b0, shutdown}, 8'h00);

    // R1 one tick short then full window
    main_uv = 1; edges(Q - 1); main_uv = 0; edges(3);
    #1 chk("R1 short hold", {7'b0, shutdown}, 8'h00);
    @(negedge clk); main_uv = 1; edges(Q);
    #1 chk("R1 at window", {7'b0, shutdown}, 8'h00);
    edges(1);
    #1 chk("R1 trip", {7'b0, shutdown}, 8'h01);
    sample_offs("R9 all off in shutdown", 4'hF);
    @(negedge clk); main_uv = 0; clear_shut();
    #1 chk("R9 cleared by enable", {7'b0, shutdown}, 8'h00);

    // R4 negative gate, cleared by deep input
    @(negedge clk); ngate_high = 1; edges(Q + 1); ngate_high = 0;
    #1 chk("R4 ngate trip", {7'b0, shutdown}, 8'h01);
    @(negedge clk); vin_deep = 1; edges(1); vin_deep = 0;
    #1 chk("R9 cleared by deep input", {7'b0, shutdown}, 8'h00);

    // R4 positive gate, sticky
    @(negedge clk); pgate_low = 1; edges(Q + 1); pgate_low = 0;
    #1 chk("R4 pgate trip", {7'b0, shutdown}, 8'h01);
    edges(5);
    #1 chk("R9 sticky", {7'b0, shutdown}, 8'h01);
    @(negedge clk); clear_shut();

    // R5 io rail window
    @(negedge clk); io_uv80 = 1; edges(Q + 1); io_uv80 = 0;
    #1 chk("R5 io trip", {7'b0, shutdown}, 8'h01);
    @(negedge clk); clear_shut();

    // R2 short window
    @(negedge clk); iso_lim_code = 4'd3; iso_over = 1; edges(S);
    #1 chk("R2 at window", {7'b0, shutdown}, 8'h00);
    edges(1);
    #1 chk("R2 trip", {7'b0, shutdown}, 8'h01);
    @(negedge clk); iso_over = 0; clear_shut();

    // R3 code zero ignored for long
    @(negedge clk); iso_lim_code = 0; iso_over = 1; edges(S + 5);
    #1 chk("R3 ignored", {6'b0, boost_off, shutdown}, 8'h00);
    @(negedge clk); iso_over = 0;

    // R6 over-current run
    @(negedge clk);
    for (int i = 0; i < RUN - 1; i++) strobe(1);
    strobe(0);
    for (int i = 0; i < RUN - 1; i++) strobe(1);
    #1 chk("R6 broken run", {6'b0, core_off, core_restart}, 8'h00);
    @(negedge clk);
    strobe(1);
    #1 chk("R6 hiccup start", {6'b0, core_off, core_restart}, 8'h02);
    edges(Q - 1);
    #1 chk("R6 hiccup end-1", {6'b0, core_off, core_restart}, 8'h02);
    edges(1);
    #1 chk("R6 restart pulse", {6'b0, core_off, core_restart}, 8'h01);
    edges(1);
    #1 chk("R6 pulse single", {6'b0, core_off, core_restart}, 8'h00);

    // R7 input undervoltage latch
    @(negedge clk); vin_uv = 1;
    sample_offs("R7 immediate", 4'hF);
    edges(1); vin_uv = 0; edges(3);
    sample_offs("R7 latched", 4'hF);
    @(negedge clk); vin_deep = 1; edges(1); vin_deep = 0;
    sample_offs("R7 released", 4'h0);
    chk("R7 no shutdown", {7'b0, shutdown}, 8'h00);

    // R8 over-temperature not latched
    @(negedge clk); ot_flag = 1; edges(4);
    sample_offs("R8 hot", 4'hF);
    ot_flag = 0;
    sample_offs("R8 cooled", 4'h0);
    chk("R8 no shutdown", {7'b0, shutdown}, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule